// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets a clocked design read and write an external asynchronous static RAM of 131,072 bytes, which needs 17 address bits and 8 data bits. The user side is a valid/ready request port. A request carries an address, a write flag and write data. The response side is a one-cycle done pulse with the read byte. The memory side has active-low chip-select, output-gate and write-strobe lines, a registered address and a split data bus. The split bus is an output value, an output enable and an input value, and the pad buffer combines them outside the block. The controller holds the memory in standby when idle, sequences each access, and owns the turnaround of the data bus so it never drives while the memory may drive.

Timing margins are given in nanoseconds together with the clock period. The access wait `W` is the larger of ceil(T_CYCLE_NS / CLK_PERIOD_NS) and ceil(T_OE_NS / CLK_PERIOD_NS), and never less than 1. An access goes through four phases:
- a one-cycle setup with chip-select low;
- an access phase of `W` cycles for a read, or `W+1` cycles for a write;
- a one-cycle recovery with all strobes high;
- return to idle.

Back-pressure: `req_ready` is high only in idle. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. While a transfer is in flight, `req_valid` and the request fields are not looked at. A requester that keeps `req_valid` high is accepted in the first idle cycle after the done pulse. The response port has no back-pressure: `rsp_done` is a pulse, and `rsp_rdata` keeps its value until the next read is captured.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, mem_ce_n, mem_oe_n and mem_we_n are 1 (standby), mem_dq_oe is 0 and req_ready is 1.
- R2: A request transfers on a clock edge with req_valid=1 and req_ready=1. From the next cycle until the cycle after the done pulse, req_ready is 0. req_valid and the request fields changing during this time start no new access and do not alter mem_addr.
- R3: A read (req_wr=0) drives mem_ce_n low for one setup cycle with both other strobes high. Then mem_oe_n is low and mem_we_n high for exactly W cycles, where W = max(ceil(T_CYCLE_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS), 1).
- R4: A write (req_wr=1) holds mem_we_n low for W+1 cycles after the setup cycle. mem_oe_n stays 1 throughout, and mem_oe_n and mem_we_n are never both 0.
- R5: mem_dq_oe rises one cycle after mem_we_n falls and falls one cycle after mem_we_n rises. It is still 1, with mem_dq_o unchanged, at the rising edge of mem_we_n. It is never 1 while mem_oe_n is 0.
- R6: Read data is sampled from mem_dq_i in the last cycle in which mem_oe_n is low. It is presented on rsp_rdata together with rsp_done and held until the next read.
- R7: rsp_done is a one-cycle pulse, issued while all strobes are high. It comes W+1 clock edges after the accepting edge for a read and W+2 for a write.
- R8: mem_addr and mem_dq_o stay constant for as long as mem_ce_n is low.
- R9: A read returns the byte most recently written to the same address, including addresses 0x00000 and 0x1FFFF and after an overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle pulse at end of an access |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 17 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | 8 | Value for the data pads |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 8 | Value seen on the data pads |

## Verification
The bench uses a wait of three cycles. It checks the exact done latency for reads and writes. A controller that counted the write turn-on cycle into the read wait, or dropped it from writes, arrives one cycle off. A behavioural memory drives the bus only while a read is gated on. It places a filler byte on the bus otherwise, so a capture taken one cycle late returns the filler instead of stored data. The model commits a write on the rising write strobe and flags any cycle where both sides drive. A data enable that dropped together with the strobe, or turned on before the strobe fell, is caught at that edge. A second request held during a busy access must neither move the address nor start early, which would corrupt the byte read back afterwards.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACCESS  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Access wait in clock cycles: larger of the two margins, at least one.
  function automatic int access_wait(input int clk_ns, input int cyc_ns, input int oe_ns);
    int a;
    int b;
    int m;
    a = ceil_div(cyc_ns, clk_ns);
    b = ceil_div(oe_ns, clk_ns);
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : m;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

  // A running access window must never find the counter already empty.
  AST_WAIT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WAIT  = 1,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic             cnt_last,
  output logic             req_ready,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_run,
  output logic             capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             done
);

  localparam logic [CNT_W-1:0] RD_LEN = CNT_W'(WAIT);
  localparam logic [CNT_W-1:0] WR_LEN = CNT_W'(WAIT + 1);

  phase_t ph_q, ph_d;
  logic   wr_q;
  logic   ce_n_q, oe_n_q, we_n_q, done_q;

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign cnt_load  = (ph_q == PH_SETUP);
  assign cnt_val   = wr_q ? WR_LEN : RD_LEN;
  assign cnt_run   = (ph_q == PH_ACCESS);
  assign capture   = (ph_q == PH_ACCESS) && cnt_last && !wr_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:    if (req_valid) ph_d = PH_SETUP;
      PH_SETUP:   ph_d = PH_ACCESS;
      PH_ACCESS:  if (cnt_last) ph_d = PH_RECOVER;
      PH_RECOVER: ph_d = PH_IDLE;
      default:    ph_d = PH_IDLE;
    endcase
  end

  // Strobes are flops loaded from the next phase, so they cannot glitch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      wr_q   <= 1'b0;
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      if (accept) wr_q <= req_wr;
      ce_n_q <= !((ph_d == PH_SETUP) || (ph_d == PH_ACCESS));
      oe_n_q <= !((ph_d == PH_ACCESS) && !wr_q);
      we_n_q <= !((ph_d == PH_ACCESS) && wr_q);
      done_q <= (ph_d == PH_RECOVER);
    end
  end

  assign ce_n = ce_n_q;
  assign oe_n = oe_n_q;
  assign we_n = we_n_q;
  assign done = done_q;

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n && we_n)); // R1
  AST_NO_GATE_AND_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && oe_n && we_n)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready); // R2

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              dq_oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      dq_oe_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_i;
      // Drive enable trails the write strobe by one cycle on both edges.
      dq_oe_q <= !we_n;
    end
  end

  assign addr  = addr_q;
  assign dq_o  = wdata_q;
  assign dq_oe = dq_oe_q;
  assign rdata = rdata_q;

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R5
  AST_DRIVE_AT_STROBE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(dq_o))); // R8
  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!oe_n && !ce_n)); // R6

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CYCLE_NS    = 10,
  parameter int T_OE_NS       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int WAIT  = access_wait(CLK_PERIOD_NS, T_CYCLE_NS, T_OE_NS);
  localparam int CNT_W = $clog2(WAIT + 2);

  logic             accept, cnt_load, cnt_run, cnt_last, capture;
  logic [CNT_W-1:0] cnt_val;

  sram_seq #(.WAIT(WAIT), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_wr    (req_wr),
    .cnt_last  (cnt_last),
    .req_ready (req_ready),
    .accept    (accept),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .cnt_run   (cnt_run),
    .capture   (capture),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .done      (rsp_done)
  );

  sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .run      (cnt_run),
    .last     (cnt_last)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_i      (mem_dq_i),
    .addr      (mem_addr),
    .dq_o      (mem_dq_o),
    .dq_oe     (mem_dq_oe),
    .rdata     (rsp_rdata)
  );

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int AW = 17;
  localparam int DW = 8;
  // CLK_PERIOD_NS=4: ceil(10/4)=3, ceil(5/4)=2, so W=3.
  localparam int W = 3;
  localparam logic [7:0] FILL = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_NS(4)) u_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // Behavioural memory: drives only while gated for read, else a filler byte.
  logic [7:0] mem [int];
  logic       model_drv;
  assign model_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  always @* begin
    if (model_drv) mem_dq_i = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    else           mem_dq_i = FILL;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: write commit on strobe rise, contention, address hold.
  logic          p_we = 1'b1, p_ce = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) check(!(mem_dq_oe && model_drv), "R5 contention", mem_dq_oe, 0);
      if (!p_ce && !mem_ce_n)
        check(mem_addr == p_addr && mem_dq_o == p_dq, "R8 hold", mem_addr, p_addr);
      if (!p_we && mem_we_n) begin
        check(mem_dq_oe && mem_dq_o == p_dq, "R5 data at strobe rise", mem_dq_oe, 1);
        mem[int'(p_addr)] = mem_dq_o;
      end
    end
    p_we = mem_we_n; p_ce = mem_ce_n; p_addr = mem_addr; p_dq = mem_dq_o;
  end

  // Issue one request; returns read byte and edges from acceptance to done.
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output int lat);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '1; req_wdata = 8'hFF; req_wr = !wr;
    lat = 0;
    while (!rsp_done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
  endtask

  localparam logic [25:0] VEC [10] = '{
    {1'b1, 17'h00000, 8'h3C}, {1'b1, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h12345, 8'h5A}, {1'b1, 17'h0AAAA, 8'h96},
    {1'b0, 17'h00000, 8'h3C}, {1'b0, 17'h1FFFF, 8'hC3},
    {1'b0, 17'h12345, 8'h5A}, {1'b0, 17'h0AAAA, 8'h96},
    {1'b1, 17'h12345, 8'hE1}, {1'b0, 17'h12345, 8'hE1}
  };

  bit done_flag = 1'b0;

  initial begin
    while (!done_flag && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int lat;
    int w_lo;
    int oe_lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes after reset",
          {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe && req_ready && !rsp_done, "R1 bus/ready after reset",
          {mem_dq_oe, req_ready, rsp_done}, 2);

    // Vector table: R7 latency, R9 read-back, R6 capture
    foreach (VEC[i]) begin
      do_op(VEC[i][25], VEC[i][24:8], VEC[i][7:0], rd, lat);
      check(lat == (VEC[i][25] ? W + 2 : W + 1), "R7 done latency", lat,
            VEC[i][25] ? W + 2 : W + 1);
      if (!VEC[i][25]) check(rd == VEC[i][7:0], "R9 R6 read data", rd, VEC[i][7:0]);
      @(negedge clk);
      check(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after access",
            {req_ready, mem_ce_n, mem_dq_oe}, 6);
    end

    // R3 read strobe shape: setup cycle then W cycles of gate low
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 17'h00000;
    @(negedge clk);
    req_valid = 1'b0;
    check(!mem_ce_n && mem_oe_n && mem_we_n, "R3 setup cycle",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3);
    oe_lo = 0;
    repeat (W + 2) begin
      @(negedge clk);
      if (!mem_oe_n) oe_lo++;
      if (!mem_we_n) oe_lo += 100;
    end
    check(oe_lo == W, "R3 gate-low cycles", oe_lo, W);

    // R4 R5 write strobe shape and drive enable
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b1; req_addr = 17'h00055; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    w_lo = 0;
    @(negedge clk);
    check(!mem_we_n && !mem_dq_oe, "R5 enable off in first strobe cycle",
          {mem_we_n, mem_dq_oe}, 0);
    w_lo++;
    repeat (W + 2) begin
      @(negedge clk);
      if (!mem_we_n) w_lo++;
      if (!mem_oe_n) w_lo += 100;
    end
    check(w_lo == W + 1, "R4 strobe-low cycles", w_lo, W + 1);
    check(!mem_dq_oe, "R5 enable off after recovery", mem_dq_oe, 0);

    // R2 request held during busy access is ignored until done
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = 1'b0; req_addr = 17'h00055;
    @(negedge clk);
    req_wr = 1'b1; req_addr = 17'h00000; req_wdata = 8'h11;
    lat = 0;
    while (!rsp_done) begin
      check(!req_ready && mem_addr == 17'h00055, "R2 busy ignores request",
            mem_addr, 17'h00055);
      @(negedge clk);
      lat++;
    end
    check(lat == W + 1 && rsp_rdata == 8'h77, "R2 first access intact", rsp_rdata, 8'h77);
    @(negedge clk);
    check(req_ready, "R2 ready after done", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_addr == 17'h00000 && !mem_ce_n, "R2 held request taken after done",
          mem_addr, 0);
    do_op(1'b0, 17'h00000, 8'h00, rd, lat);
    check(rd == 8'h11, "R9 held write landed", rd, 8'h11);

    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule